// File: doc/BRIEF.md
# Dual-Slope / Single-Slope 16-bit PWM Timer

This block is a 16-bit timer/counter that produces pulse-width-modulated waveforms on two output channels, A and B. A clock-enable prescaler sets the rate at which the counter advances. A 4-bit mode field selects two things: single-slope ("fast") counting or dual-slope ("phase-correct") counting, and the source of the TOP value. TOP can be a fixed 8/9/10-bit limit, a capture register that software writes, or the active compare value of channel A.

Each channel holds its compare value in a write buffer. The buffer is copied into the active compare register only when the counter passes TOP, so a new duty value never cuts a period short. A 2-bit compare-output setting per channel chooses between four behaviours: output off, toggle on match (channel A only), non-inverted PWM, and inverted PWM. A register-write port loads the compare buffers, the capture register and the counter itself. The counter can also be stopped by the mode field.

Top module: `pwm16_timer`

## Requirements
- R1: `clk_sel` sets the step rate as follows: 1 = every clock, 2 = one step per 8 clocks, 3 = per 64, 4 = per 256, 5 = per 1024. Codes 0, 6 and 7 give no steps.
- R2: `mode` encoding. Bit 3 is 0 for fast and 1 for phase-correct. Bits 2:0 choose TOP: 1 = 0x00FF, 2 = 0x01FF, 3 = 0x03FF, 4 = capture register, 5 = active compare A. Any other value of bits 2:0 stops the counter. While stopped, compare writes reach the active registers on the following clock.
- R3: In fast mode the count runs 0..TOP. The step taken at TOP returns it to 0 and pulses `ovf_pulse`, so the period is TOP+1 steps.
- R4: A count already above TOP keeps rising to 0xFFFF and wraps to 0 before it can meet TOP.
- R5: In phase-correct mode the count runs 0 up to TOP and back down to 0, so the period is 2·TOP steps. `ovf_pulse` marks the step leaving 0 while counting down.
- R6: `wr_sel` codes are 0 = compare A buffer, 1 = compare B buffer, 2 = capture, 3 = counter. In a running mode a buffered compare value becomes active only on the step taken at TOP.
- R7: Compare-output codes are 0 = off, 1 = toggle, 2 = non-inverted, 3 = inverted. In fast mode with code 2, the output is high from the TOP-to-0 step up to the match step, which gives OCR+1 high steps. OCR=0 gives a one-step spike and OCR=TOP gives a constant high. Code 3 is the complement.
- R8: In phase-correct mode with code 2, a match while rising clears the output and a match while falling sets it, which gives 2·OCR high steps. OCR=0 gives a constant low and OCR=TOP a constant high. Code 3 is the complement.
- R9: Code 1 on channel A toggles the output on each match. With mode 5 and compare A = 0, the output toggles on every step. Code 0 holds an output low, and so does code 1 on channel B.
- R10: A counter write takes priority over a step in the same clock. The first step after the write performs no compare action and raises no match flag.
- R11: `match_a`/`match_b` are high for the one clock whose closing edge performs a step at a count equal to the active compare value.
- R12: After reset the outputs and flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 cmp A, 1 cmp B, 2 capture, 3 counter |
| wr_data | input | 16 | Write value |
| clk_sel | input | 3 | Prescaler select |
| mode | input | 4 | Counting mode and TOP source |
| com_a | input | 2 | Compare-output code, channel A |
| com_b | input | 2 | Compare-output code, channel B |
| wave_a | output | 1 | Waveform, channel A |
| wave_b | output | 1 | Waveform, channel B |
| ovf_pulse | output | 1 | Overflow step marker |
| match_a | output | 1 | Compare-match step marker, channel A |
| match_b | output | 1 | Compare-match step marker, channel B |

## Verification
A wrong count or direction shows up within one period as a wrong spacing between overflow pulses. A wrong active compare value, or a load at the wrong step, shows up as a wrong number of high clocks in the first full period after the change. The bench therefore measures period and high time over whole periods for each mode, prescale and polarity. It also checks that a write made mid-period leaves the current period untouched and changes the next one. The wrap past a lowered TOP is caught by counting clocks to the next overflow. A missing match block is caught one step after the counter write, where the output must stay high.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;

  localparam logic [1:0] SEL_CMPA = 2'd0;
  localparam logic [1:0] SEL_CMPB = 2'd1;
  localparam logic [1:0] SEL_CAP  = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;

  localparam logic [1:0] COM_OFF  = 2'd0;
  localparam logic [1:0] COM_TGL  = 2'd1;
  localparam logic [1:0] COM_NINV = 2'd2;
  localparam logic [1:0] COM_INV  = 2'd3;

  typedef enum logic [2:0] {
    TOP_FIX8  = 3'd0,
    TOP_FIX9  = 3'd1,
    TOP_FIX10 = 3'd2,
    TOP_CAP   = 3'd3,
    TOP_CMPA  = 3'd4
  } top_src_e;

  typedef struct packed {
    logic     run;
    logic     dual;
    top_src_e src;
  } mode_t;

  function automatic mode_t decode_mode(input logic [3:0] m);
    mode_t d;
    d.run  = 1'b1;
    d.dual = m[3];
    d.src  = TOP_FIX8;
    case (m[2:0])
      3'd1:    d.src = TOP_FIX8;
      3'd2:    d.src = TOP_FIX9;
      3'd3:    d.src = TOP_FIX10;
      3'd4:    d.src = TOP_CAP;
      3'd5:    d.src = TOP_CMPA;
      default: d.run = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pwm16_prescale.sv
module pwm16_prescale #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q, pre_d, mask;
  logic             valid;

  always_comb pre_d = pre_q + PRE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  always_comb begin
    valid = 1'b1;
    mask  = '0;
    case (clk_sel)
      3'd1:    mask = PRE_W'(0);
      3'd2:    mask = PRE_W'(7);
      3'd3:    mask = PRE_W'(63);
      3'd4:    mask = PRE_W'(255);
      3'd5:    mask = PRE_W'(1023);
      default: valid = 1'b0;
    endcase
    tick = valid && ((pre_q & mask) == mask);
  end

  AST_DIV8_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clk_sel == 3'd2) |=> (!tick || clk_sel != 3'd2)); // R1

endmodule

// File: rtl/pwm16_counter.sv
module pwm16_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         dual,
  input  logic [W-1:0] top,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cnt_q,
  output logic         up_q,
  output logic         blk_q,
  output logic         step,
  output logic         at_top,
  output logic         load_cmp,
  output logic         ovf
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_d;
  logic         up_d, blk_d;

  always_comb begin
    step     = tick && run && !wr_cnt;
    at_top   = (cnt_q == top);
    cnt_d    = cnt_q;
    up_d     = up_q;
    blk_d    = blk_q;
    ovf      = 1'b0;
    load_cmp = !run;
    if (!run) up_d = 1'b1;
    if (wr_cnt) begin
      cnt_d = wr_val;
      blk_d = 1'b1;
    end else if (step) begin
      blk_d = 1'b0;
      if (!dual) begin
        if (at_top) begin
          cnt_d    = '0;
          ovf      = 1'b1;
          load_cmp = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (up_q) begin
        if (at_top) begin
          cnt_d    = cnt_q - ONE;
          up_d     = 1'b0;
          load_cmp = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (cnt_q == '0) begin
        cnt_d = ONE;
        up_d  = 1'b1;
        ovf   = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      blk_q <= blk_d;
    end
  end

  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_cnt) |=> $stable(cnt_q)); // R2
  AST_FAST_CLEAR_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !dual && at_top) |=> (cnt_q == '0)); // R3
  AST_WRAP_PAST_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && up_q && !at_top && cnt_q == '1) |=> (cnt_q == '0)); // R4
  AST_DUAL_TURN_AT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dual && !up_q && cnt_q == '0) |=> (cnt_q == ONE && up_q)); // R5

endmodule

// File: rtl/pwm16_chan.sv
module pwm16_chan import pwm16_pkg::*; #(
  parameter int W          = 16,
  parameter bit CAN_TOGGLE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_buf,
  input  logic [W-1:0] wr_val,
  input  logic         load,
  input  logic         step,
  input  logic         dual,
  input  logic         up,
  input  logic         at_top,
  input  logic         blk,
  input  logic [W-1:0] cnt,
  input  logic [1:0]   com,
  output logic [W-1:0] cmp_q,
  output logic         match,
  output logic         wave_q
);

  logic [W-1:0] buf_q, buf_d, cmp_d;
  logic         hit, set_dual, pol, wave_d;

  always_comb begin
    buf_d    = wr_buf ? wr_val : buf_q;
    cmp_d    = load ? buf_q : cmp_q;
    hit      = (cnt == cmp_q) && !blk;
    match    = step && hit;
    set_dual = at_top || (!up && (cnt != '0));
    pol      = (com == COM_INV);
    wave_d   = wave_q;
    case (com)
      COM_OFF: wave_d = 1'b0;
      COM_TGL: begin
        if (!CAN_TOGGLE)   wave_d = 1'b0;
        else if (match)    wave_d = !wave_q;
      end
      default: begin
        if (step) begin
          if (!dual) begin
            if (at_top)   wave_d = !pol;
            else if (hit) wave_d = pol;
          end else if (hit) begin
            wave_d = set_dual ^ pol;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      cmp_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      cmp_q  <= cmp_d;
      wave_q <= wave_d;
    end
  end

  AST_CMP_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cmp_q)); // R6
  AST_BLOCKED_NO_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    (step && blk && !at_top && com != COM_OFF) |=> $stable(wave_q)); // R10
  AST_OFF_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (com == COM_OFF) |=> !wave_q); // R9

endmodule

// File: rtl/pwm16_timer.sv
module pwm16_timer import pwm16_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       clk_sel,
  input  logic [3:0]       mode,
  input  logic [1:0]       com_a,
  input  logic [1:0]       com_b,
  output logic             wave_a,
  output logic             wave_b,
  output logic             ovf_pulse,
  output logic             match_a,
  output logic             match_b
);

  localparam int NCH = 2;

  mode_t            md;
  logic             tick, wr_cnt, step, at_top, load_cmp, up, blk;
  logic [CNT_W-1:0] cap_q, cap_d, top, cnt;
  logic [CNT_W-1:0] cmp_act [NCH];
  logic [1:0]       com_v   [NCH];
  logic [NCH-1:0]   wave_v, match_v;

  always_comb begin
    md       = decode_mode(mode);
    wr_cnt   = wr_en && (wr_sel == SEL_CNT);
    cap_d    = (wr_en && wr_sel == SEL_CAP) ? wr_data : cap_q;
    com_v[0] = com_a;
    com_v[1] = com_b;
    case (md.src)
      TOP_FIX9:  top = CNT_W'(16'h01FF);
      TOP_FIX10: top = CNT_W'(16'h03FF);
      TOP_CAP:   top = cap_q;
      TOP_CMPA:  top = cmp_act[0];
      default:   top = CNT_W'(16'h00FF);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end

  pwm16_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_sel (clk_sel),
    .tick    (tick)
  );

  pwm16_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run      (md.run),
    .dual     (md.dual),
    .top      (top),
    .wr_cnt   (wr_cnt),
    .wr_val   (wr_data),
    .cnt_q    (cnt),
    .up_q     (up),
    .blk_q    (blk),
    .step     (step),
    .at_top   (at_top),
    .load_cmp (load_cmp),
    .ovf      (ovf_pulse)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm16_chan #(.W(CNT_W), .CAN_TOGGLE(ch == 0)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_buf (wr_en && (wr_sel == 2'(ch))),
      .wr_val (wr_data),
      .load   (load_cmp),
      .step   (step),
      .dual   (md.dual),
      .up     (up),
      .at_top (at_top),
      .blk    (blk),
      .cnt    (cnt),
      .com    (com_v[ch]),
      .cmp_q  (cmp_act[ch]),
      .match  (match_v[ch]),
      .wave_q (wave_v[ch])
    );
  end

  assign wave_a  = wave_v[0];
  assign wave_b  = wave_v[1];
  assign match_a = match_v[0];
  assign match_b = match_v[1];

  AST_OVF_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (tick && md.run)); // R11
  AST_CAP_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CAP) |=> (cap_q == $past(wr_data))); // R6

endmodule

// File: tb/pwm16_timer_test.sv
`timescale 1ns/1ps
module pwm16_timer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic [2:0]  clk_sel;
  logic [3:0]  mode;
  logic [1:0]  com_a, com_b;
  logic        wave_a, wave_b, ovf_pulse, match_a, match_b;

  int errors = 0;
  int total  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwm16_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .clk_sel(clk_sel), .mode(mode), .com_a(com_a), .com_b(com_b),
    .wave_a(wave_a), .wave_b(wave_b), .ovf_pulse(ovf_pulse),
    .match_a(match_a), .match_b(match_b)
  );

  // mode, clk_sel, cap, ocr_a, ocr_b, com_a, com_b, period, high_a, high_b (clocks)
  localparam int NV = 13;
  localparam int VEC [NV][10] = '{
    '{ 4, 1,  9,    3,   9, 2, 2,   10,    4,   10},
    '{ 4, 1,  9,    0,   4, 2, 3,   10,    1,    5},
    '{ 1, 1,  0,  127, 255, 3, 3,  256,  128,    0},
    '{ 3, 1,  0,  511,   0, 2, 2, 1024,  512,    1},
    '{ 2, 2,  0,   99,   0, 2, 3, 4096,  800, 4088},
    '{ 5, 3,  0,    7,   3, 0, 2,  512,    0,  256},
    '{12, 1, 10,    4,  10, 2, 2,   20,    8,   20},
    '{12, 1, 10,    0,   3, 2, 3,   20,    0,   14},
    '{ 9, 1,  0,   64, 255, 3, 2,  510,  382,  510},
    '{10, 1,  0,  100, 511, 2, 3, 1022,  200,    0},
    '{13, 4,  0,    3,   1, 0, 2, 1536,    0,  512},
    '{11, 1,  0, 1023,   3, 2, 2, 2046, 2046,    6},
    '{ 4, 5,  3,    1,   3, 2, 2, 4096, 2048, 4096}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] sel, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = 16'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic configure(input int md, input int cs, input int cap, input int oa,
                           input int ob, input int ca, input int cb);
    @(negedge clk);
    mode = 4'd0;
    write_reg(2'd2, cap);
    write_reg(2'd0, oa);
    write_reg(2'd1, ob);
    write_reg(2'd3, 0);
    @(negedge clk);
    clk_sel = 3'(cs); com_a = 2'(ca); com_b = 2'(cb); mode = 4'(md);
  endtask

  task automatic wait_ovf();
    do @(negedge clk); while (!ovf_pulse);
  endtask

  task automatic measure(output int per, output int ha, output int hb);
    wait_ovf();
    per = 0; ha = 0; hb = 0;
    do begin
      @(negedge clk);
      per++;
      ha += int'(wave_a);
      hb += int'(wave_b);
    end while (!ovf_pulse);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; total++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end

  initial begin
    int per, ha, hb, h, n;
    string rp, rw;
    logic prev;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    clk_sel = '0; mode = '0; com_a = '0; com_b = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: outputs low after reset
    chk(!wave_a && !wave_b, "R12 waves after reset", int'(wave_a) + int'(wave_b), 0);
    chk(!ovf_pulse && !match_a && !match_b, "R12 flags after reset",
        int'(ovf_pulse) + int'(match_a) + int'(match_b), 0);

    // vector table: R1/R2/R3/R5 period, R7/R8 high time
    for (int i = 0; i < NV; i++) begin
      configure(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], VEC[i][6]);
      measure(per, ha, hb);
      rp = (VEC[i][0] >= 8) ? "R5 R2 period" : "R3 R2 period";
      if (VEC[i][1] > 1) rp = {rp, " R1"};
      rw = (VEC[i][0] >= 8) ? "R8" : "R7";
      chk(per == VEC[i][7], $sformatf("%s vec%0d", rp, i), per, VEC[i][7]);
      chk(ha == VEC[i][8], $sformatf("%s high A vec%0d", rw, i), ha, VEC[i][8]);
      chk(hb == VEC[i][9], $sformatf("%s high B vec%0d", rw, i), hb, VEC[i][9]);
    end

    // R6: mid-period compare write waits for TOP
    configure(4, 1, 9, 0, 4, 0, 2);
    measure(per, ha, hb);
    @(negedge clk);
    h = int'(wave_b);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd7;
    do begin
      @(negedge clk);
      wr_en = 1'b0;
      h += int'(wave_b);
    end while (!ovf_pulse);
    chk(h == 5, "R6 old compare kept in current period", h, 5);
    measure(per, ha, hb);
    chk(hb == 8, "R6 new compare after TOP", hb, 8);

    // R10/R11: counter write blocks next match
    configure(4, 1, 20, 5, 0, 2, 0);
    measure(per, ha, hb);
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'd5;
    @(negedge clk);
    wr_en = 1'b0;
    chk(!match_a, "R10 R11 no match flag on blocked step", int'(match_a), 0);
    @(negedge clk);
    chk(wave_a, "R10 output unchanged after blocked match", int'(wave_a), 1);
    measure(per, ha, hb);
    chk(ha == 6, "R10 next period normal", ha, 6);

    // R9/R11: toggle at half the step rate
    configure(5, 1, 0, 0, 0, 1, 1);
    repeat (5) @(negedge clk);
    prev = wave_a;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(wave_a == !prev && match_a && ovf_pulse && !wave_b,
          "R9 R11 toggle each step", int'(wave_a), int'(!prev));
      prev = wave_a;
    end

    // R1: clk_sel 0 gives no steps
    configure(4, 0, 9, 3, 3, 2, 2);
    n = 0;
    repeat (100) begin @(negedge clk); n += int'(ovf_pulse); end
    chk(n == 0, "R1 no overflow with prescaler off", n, 0);

    // R2: unused mode stops counter
    configure(7, 1, 9, 3, 3, 2, 2);
    n = 0;
    repeat (100) begin @(negedge clk); n += int'(ovf_pulse); end
    chk(n == 0, "R2 no overflow in unused mode", n, 0);

    // R4: count above TOP wraps through 0xFFFF
    configure(0, 1, 100, 0, 0, 0, 0);
    @(negedge clk);
    mode = 4'd4; clk_sel = 3'd1;
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'd200;
    @(negedge clk);
    wr_en = 1'b0;
    n = 1;
    while (!ovf_pulse && n < 70000) begin
      @(negedge clk);
      n++;
    end
    chk(n == 65437, "R4 wrap past lowered TOP", n, 65437);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

endmodule